// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory for a small set of caching nodes that keep their copies consistent with an invalidation protocol. The block holds one directory entry per memory block. Each entry has a three-way sharing state (uncached, shared or modified), one presence bit per node and a busy flag. The block also holds a small data store for its memory blocks. Nodes send it read misses, write misses, writebacks and acknowledgements through a single valid/ready port. The block answers on one registered message port with data replies, exclusive grants, invalidations, forwarded reads and negative acknowledgements.

The controller orders all coherence traffic for a block. A write miss to a block that other nodes share sends invalidations to those nodes one per cycle. The controller then counts the acknowledgements and grants ownership only after the last one arrives. A read miss to a modified block is forwarded to the owner. The owner's writeback closes that transaction. Only one such multi-message transaction is open at a time. A conflicting request gets a negative acknowledgement and is not queued, and the sender retries it later. Requests that can be answered at once are still served while a transaction is open.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `outValid` is 0 and `reqReady` is 1. Every entry is uncached with no sharers, and every memory word is 0.
- R2: A read (`reqKind`=0) to an uncached block replies DATA (`outKind`=2) to the source with the memory word. The source becomes the only sharer, and the block becomes shared.
- R3: A read-exclusive (`reqKind`=1) to an uncached block replies EXCL (`outKind`=3) to the source with the memory word. The block becomes modified, owned by the source.
- R4: A read to a shared block replies DATA with the memory word and adds the source to the sharers. The block stays shared.
- R5: A read-exclusive to a shared block with other sharers drives `reqReady` low. It then sends INV (`outKind`=0) once per cycle to each sharer other than the requester, lowest node number first. `reqReady` returns to 1 in the cycle the last INV appears.
- R6: Each acknowledgement (`reqKind`=3) from a pending sharer clears that sharer's bit and produces no message. The last one sends EXCL to the requester. The requester becomes the only sharer, and the block becomes modified.
- R7: A read-exclusive from the only sharer of a shared block, or from the owner of a modified block, is granted EXCL at once, with no INV.
- R8: A read to a modified block sends FWD (`outKind`=1) to the owner. The owner's writeback (`reqKind`=2) then stores its data to memory and replies DATA with that data to the reader. The block becomes shared by both nodes.
- R9: A read-exclusive to a modified block sends INV to the owner. The owner's acknowledgement data is stored to memory and returned to the requester with EXCL, and the block stays modified.
- R10: A writeback from the owner of a modified block stores the data, clears the sharers and makes the block uncached, with no message. A writeback from any other node, or to a block that is not modified, changes nothing and sends nothing.
- R11: A read, read-exclusive or writeback to a busy block (a transaction is open on it) gets NACK (`outKind`=4) to the source and changes nothing. The only exception is the closing writeback of R8.
- R12: While a transaction is open, a request that would open another one is NACKed. Requests to other blocks that complete at once are served normally.
- R13: A reply to an accepted request appears on the port in the cycle after the accepting edge. INV and FWD begin one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqKind | input | 2 | 0 read, 1 read-exclusive, 2 writeback, 3 acknowledgement |
| reqSrc | input | NODE_W | Sending node |
| reqAddr | input | ADDR_W | Block index |
| reqData | input | DATA_W | Writeback or acknowledgement data |
| outValid | output | 1 | Message valid for one cycle |
| outKind | output | 3 | 0 INV, 1 FWD, 2 DATA, 3 EXCL, 4 NACK |
| outDst | output | NODE_W | Destination node |
| outAddr | output | ADDR_W | Block index of the message |
| outData | output | DATA_W | Block data for DATA and EXCL |

## Verification
A wrong presence vector shows at the ports as a missing or extra INV in the cycles after a write miss. It can also show as an EXCL that comes too early or never comes. A stale busy flag or transaction record shows as a NACK where a reply was due, or the reverse, on the very next request to that block. Data lost on a writeback or forwarded read stays hidden until a later read of the block. For that reason each store is followed by a read that returns the stored word within two requests.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;
  typedef enum logic [1:0] {ST_UNC, ST_SHR, ST_MOD} dirState_e;
  typedef enum logic [1:0] {REQ_RD, REQ_RDX, REQ_WB, REQ_ACK} reqKind_e;
  typedef enum logic [2:0] {MSG_INV, MSG_FWD, MSG_DATA, MSG_EXCL, MSG_NACK} msgKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      wrEntry;
    dirState_e newState;
    logic      setBusy;
    logic      clrBusy;
    logic      wrMem;
    logic      sendOut;
    msgKind_e  outKind;
    logic      useInData;
  } dirStrobe_t;
endpackage

// File: rtl/dir_datapath.sv
`timescale 1ns/1ps
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  parameter int NODE_W = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        st,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NODES-1:0]  newPres,
  input  logic [DATA_W-1:0] inData,
  input  logic [NODE_W-1:0] dstIn,
  input  logic [ADDR_W-1:0] msgAddrIn,
  output dirState_e         curState,
  output logic [NODES-1:0]  curPres,
  output logic              curBusy,
  output logic              outValid,
  output msgKind_e          outKind,
  output logic [NODE_W-1:0] outDst,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);
  dirState_e          stateQ [BLOCKS];
  logic [NODES-1:0]   presQ  [BLOCKS];
  logic [DATA_W-1:0]  memQ   [BLOCKS];
  logic [BLOCKS-1:0]  busyQ;
  logic [DATA_W-1:0]  curMem;

  assign curState = stateQ[addr];
  assign curPres  = presQ[addr];
  assign curBusy  = busyQ[addr];
  assign curMem   = memQ[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BLOCKS; i++) begin
        stateQ[i] <= ST_UNC;
        presQ[i]  <= '0;
        memQ[i]   <= '0;
      end
      busyQ    <= '0;
      outValid <= 1'b0;
      outKind  <= MSG_INV;
      outDst   <= '0;
      outAddr  <= '0;
      outData  <= '0;
    end else begin
      if (st.wrEntry) begin
        stateQ[addr] <= st.newState;
        presQ[addr]  <= newPres;
      end
      if (st.setBusy) busyQ[addr] <= 1'b1;
      if (st.clrBusy) busyQ[addr] <= 1'b0;
      if (st.wrMem)   memQ[addr]  <= inData;
      outValid <= st.sendOut;
      if (st.sendOut) begin
        outKind <= st.outKind;
        outDst  <= dstIn;
        outAddr <= msgAddrIn;
        outData <= st.useInData ? inData : curMem;
      end
    end
  end
endmodule

// File: rtl/dir_control.sv
`timescale 1ns/1ps
module dir_control
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int NODE_W = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  reqKind_e          reqKind,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  dirState_e         curState,
  input  logic [NODES-1:0]  curPres,
  input  logic              curBusy,
  output logic              reqReady,
  output dirStrobe_t        st,
  output logic [NODES-1:0]  newPres,
  output logic [NODE_W-1:0] dstOut,
  output logic [ADDR_W-1:0] msgAddr
);
  localparam int CNT_W = NODE_W + 1;

  function automatic logic [NODES-1:0] nodeBit(input logic [NODE_W-1:0] idx);
    nodeBit = {{(NODES-1){1'b0}}, 1'b1} << idx;
  endfunction

  function automatic logic [NODE_W-1:0] lowIdx(input logic [NODES-1:0] v);
    lowIdx = '0;
    for (int i = NODES - 1; i >= 0; i--) if (v[i]) lowIdx = NODE_W'(i);
  endfunction

  function automatic logic [CNT_W-1:0] popCount(input logic [NODES-1:0] v);
    popCount = '0;
    for (int i = 0; i < NODES; i++) popCount = popCount + CNT_W'(v[i]);
  endfunction

  // open-transaction record
  logic              txnActive, txnIsRead, sending;
  logic [ADDR_W-1:0] txnAddr;
  logic [NODE_W-1:0] txnReq;
  logic [NODES-1:0]  invVec;
  logic [CNT_W-1:0]  ackCnt;

  logic             startTxn, startRead, ackTake, txnDone;
  logic [NODES-1:0] startVec, srcBit, otherPres, walkLow;
  logic             matchTxn;

  assign reqReady  = !sending;
  assign srcBit    = nodeBit(reqSrc);
  assign otherPres = curPres & ~srcBit;
  assign matchTxn  = txnActive && (reqAddr == txnAddr);
  assign walkLow   = nodeBit(lowIdx(invVec));

  always_comb begin
    st        = '0;
    newPres   = curPres;
    dstOut    = reqSrc;
    msgAddr   = reqAddr;
    startTxn  = 1'b0;
    startRead = 1'b0;
    startVec  = '0;
    ackTake   = 1'b0;
    txnDone   = 1'b0;
    if (sending) begin
      st.sendOut = 1'b1;
      st.outKind = txnIsRead ? MSG_FWD : MSG_INV;
      dstOut     = lowIdx(invVec);
      msgAddr    = txnAddr;
    end else if (reqValid) begin
      unique case (reqKind)
        REQ_ACK: begin
          if (matchTxn && !txnIsRead && curPres[reqSrc]) begin
            ackTake     = 1'b1;
            st.wrEntry  = 1'b1;
            st.newState = curState;
            newPres     = otherPres;
            st.wrMem    = (curState == ST_MOD);
            if (ackCnt == CNT_W'(1)) begin
              txnDone      = 1'b1;
              newPres      = nodeBit(txnReq);
              st.newState  = ST_MOD;
              st.clrBusy   = 1'b1;
              st.sendOut   = 1'b1;
              st.outKind   = MSG_EXCL;
              st.useInData = (curState == ST_MOD);
              dstOut       = txnReq;
            end
          end
        end
        REQ_WB: begin
          if (curBusy) begin
            st.sendOut = 1'b1;
            st.outKind = MSG_NACK;
            if (matchTxn && txnIsRead && curPres[reqSrc] && curState == ST_MOD) begin
              txnDone      = 1'b1;
              st.wrMem     = 1'b1;
              st.wrEntry   = 1'b1;
              st.newState  = ST_SHR;
              newPres      = curPres | nodeBit(txnReq);
              st.clrBusy   = 1'b1;
              st.outKind   = MSG_DATA;
              st.useInData = 1'b1;
              dstOut       = txnReq;
            end
          end else if (curState == ST_MOD && curPres == srcBit) begin
            st.wrMem    = 1'b1;
            st.wrEntry  = 1'b1;
            st.newState = ST_UNC;
            newPres     = '0;
          end
        end
        REQ_RD: begin
          st.sendOut = 1'b1;
          st.outKind = MSG_NACK;
          if (!curBusy) begin
            if (curState != ST_MOD) begin
              st.outKind  = MSG_DATA;
              st.wrEntry  = 1'b1;
              st.newState = ST_SHR;
              newPres     = (curState == ST_UNC) ? srcBit : (curPres | srcBit);
            end else if (!txnActive) begin
              st.sendOut = 1'b0;
              st.setBusy = 1'b1;
              startTxn   = 1'b1;
              startRead  = 1'b1;
              startVec   = curPres;
            end
          end
        end
        default: begin // REQ_RDX
          st.sendOut = 1'b1;
          st.outKind = MSG_NACK;
          if (!curBusy) begin
            if (curState == ST_UNC || otherPres == '0) begin
              st.outKind  = MSG_EXCL;
              st.wrEntry  = 1'b1;
              st.newState = ST_MOD;
              newPres     = srcBit;
            end else if (!txnActive) begin
              st.sendOut = 1'b0;
              st.setBusy = 1'b1;
              startTxn   = 1'b1;
              startVec   = otherPres;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txnActive <= 1'b0;
      txnIsRead <= 1'b0;
      sending   <= 1'b0;
      txnAddr   <= '0;
      txnReq    <= '0;
      invVec    <= '0;
      ackCnt    <= '0;
    end else begin
      if (sending) begin
        invVec <= invVec & ~walkLow;
        if ((invVec & ~walkLow) == '0) sending <= 1'b0;
      end
      if (startTxn) begin
        txnActive <= 1'b1;
        txnIsRead <= startRead;
        txnAddr   <= reqAddr;
        txnReq    <= reqSrc;
        invVec    <= startVec;
        ackCnt    <= popCount(startVec);
        sending   <= 1'b1;
      end
      if (ackTake) ackCnt <= ackCnt - CNT_W'(1);
      if (txnDone) txnActive <= 1'b0;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
`timescale 1ns/1ps
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  parameter int NODE_W = $clog2(NODES),
  parameter int ADDR_W = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              outValid,
  output logic [2:0]        outKind,
  output logic [NODE_W-1:0] outDst,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);
  dirStrobe_t        st;
  dirState_e         curState;
  logic [NODES-1:0]  curPres, newPres;
  logic              curBusy;
  logic [NODE_W-1:0] dstOut;
  logic [ADDR_W-1:0] msgAddr;
  msgKind_e          kindOut;

  dir_control #(.NODES(NODES), .NODE_W(NODE_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind_e'(reqKind)),
    .reqSrc(reqSrc), .reqAddr(reqAddr), .curState(curState), .curPres(curPres),
    .curBusy(curBusy), .reqReady(reqReady), .st(st), .newPres(newPres),
    .dstOut(dstOut), .msgAddr(msgAddr)
  );

  dir_datapath #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W),
                 .NODE_W(NODE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .addr(reqAddr), .newPres(newPres),
    .inData(reqData), .dstIn(dstOut), .msgAddrIn(msgAddr), .curState(curState),
    .curPres(curPres), .curBusy(curBusy), .outValid(outValid), .outKind(kindOut),
    .outDst(outDst), .outAddr(outAddr), .outData(outData)
  );

  assign outKind = kindOut;
endmodule

// File: rtl/dir_home_ctrl_chk.sv
`timescale 1ns/1ps
module dir_home_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       outValid,
  input logic [2:0] outKind
);
  logic isWalk;
  assign isWalk = outValid && (outKind == 3'd0 || outKind == 3'd1);

  // R5: invalidations and forwards leave only while intake is closed
  assert_walk_blocks_intake_R5: assert property (@(posedge clk) disable iff (!rstN)
    isWalk |-> !$past(reqReady));

  // R5: intake reopens together with the last walk message
  assert_walk_ends_with_msg_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> isWalk);

  // R6: a grant never overlaps a walk
  assert_grant_outside_walk_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 3'd3) |-> reqReady);

  // R11: a refusal answers an accepted request
  assert_nack_answers_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 3'd4) |-> $past(reqValid && reqReady));

  // R13: a data reply follows an accepted request by one cycle
  assert_data_timing_R13: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 3'd2) |-> $past(reqValid && reqReady));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .outValid(outValid), .outKind(outKind)
);

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;
  localparam logic [1:0] RD = 2'd0, RDX = 2'd1, WB = 2'd2, ACK = 2'd3;
  localparam logic [2:0] INV = 3'd0, FWD = 3'd1, DAT = 3'd2, EXC = 3'd3, NAK = 3'd4;
  localparam int NV = 9;

  // table: rows 0 R2, 1 R4, 2 R3, 3 R10, 4 R2/R10, 5 R7, 6 R10, 7 R10, 8 R4
  localparam logic [1:0]  V_KIND [NV] = '{RD, RD, RDX, WB, RD, RDX, WB, RD, RD};
  localparam logic [1:0]  V_SRC  [NV] = '{0, 1, 2, 2, 3, 3, 0, 0, 2};
  localparam logic [2:0]  V_ADDR [NV] = '{1, 1, 3, 3, 3, 3, 5, 5, 1};
  localparam logic [15:0] V_DATA [NV] = '{0, 0, 0, 16'h1234, 0, 0, 16'hdead, 0, 0};
  localparam logic        E_VAL  [NV] = '{1, 1, 1, 0, 1, 1, 0, 1, 1};
  localparam logic [2:0]  E_KIND [NV] = '{DAT, DAT, EXC, DAT, DAT, EXC, DAT, DAT, DAT};
  localparam logic [1:0]  E_DST  [NV] = '{0, 1, 2, 0, 3, 3, 0, 0, 2};
  localparam logic [15:0] E_DATA [NV] = '{0, 0, 0, 0, 16'h1234, 16'h1234, 0, 0, 0};

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqKind = '0, reqSrc = '0;
  logic [2:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic outValid;
  logic [2:0] outKind, outAddr;
  logic [1:0] outDst;
  logic [15:0] outData;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dir_home_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqSrc(reqSrc), .reqAddr(reqAddr), .reqData(reqData),
    .outValid(outValid), .outKind(outKind), .outDst(outDst), .outAddr(outAddr),
    .outData(outData)
  );

  // called at a falling edge; returns at the falling edge after the accept
  task automatic send(input logic [1:0] k, input logic [1:0] s, input logic [2:0] a,
                      input logic [15:0] d);
    reqValid = 1'b1; reqKind = k; reqSrc = s; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic v, input logic [2:0] k,
                            input logic [1:0] dst, input logic [2:0] a,
                            input logic [15:0] d);
    checks++;
    if (!v) begin
      if (outValid !== 1'b0) begin
        errors++;
        $display("FAIL %s: outValid=%b kind=%0d expected no message", tag, outValid, outKind);
      end
    end else if (outValid !== 1'b1 || outKind !== k || outDst !== dst || outAddr !== a ||
                 ((k == DAT || k == EXC) && outData !== d)) begin
      errors++;
      $display("FAIL %s: got v=%b kind=%0d dst=%0d addr=%0d data=%h expected v=1 kind=%0d dst=%0d addr=%0d data=%h",
               tag, outValid, outKind, outDst, outAddr, outData, k, dst, a, d);
    end
  endtask

  task automatic expect_ready(input string tag, input logic exp);
    checks++;
    if (reqReady !== exp) begin
      errors++;
      $display("FAIL %s: reqReady=%b expected %b", tag, reqReady, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expect_msg("R1 reset", 1'b0, INV, 0, 0, 0);
    expect_ready("R1 reset", 1'b1);

    for (int i = 0; i < NV; i++) begin
      send(V_KIND[i], V_SRC[i], V_ADDR[i], V_DATA[i]);
      expect_msg($sformatf("table row %0d", i), E_VAL[i], E_KIND[i], E_DST[i], V_ADDR[i], E_DATA[i]);
    end

    // R5: block 1 shared by 0,1,2; node 1 asks for ownership
    send(RDX, 1, 1, 0);
    expect_msg("R13 no reply on walk start", 1'b0, INV, 0, 0, 0);
    expect_ready("R5 intake closed", 1'b0);
    @(negedge clk);
    expect_msg("R5 inv node0", 1'b1, INV, 0, 1, 0);
    @(negedge clk);
    expect_msg("R5 inv node2", 1'b1, INV, 2, 1, 0);
    expect_ready("R5 intake reopened", 1'b1);
    send(RD, 3, 1, 0);
    expect_msg("R11 busy read nacked", 1'b1, NAK, 3, 1, 0);
    send(RDX, 3, 6, 0);
    expect_msg("R12 other block served", 1'b1, EXC, 3, 6, 0);
    send(RD, 0, 6, 0);
    expect_msg("R12 second transaction nacked", 1'b1, NAK, 0, 6, 0);
    send(ACK, 0, 1, 0);
    expect_msg("R6 first ack silent", 1'b0, INV, 0, 0, 0);
    send(ACK, 2, 1, 0);
    expect_msg("R6 grant after last ack", 1'b1, EXC, 1, 1, 0);

    // R8: node 0 reads block 1 owned by node 1
    send(RD, 0, 1, 0);
    expect_msg("R8 forward start", 1'b0, INV, 0, 0, 0);
    @(negedge clk);
    expect_msg("R8 fwd to owner", 1'b1, FWD, 1, 1, 0);
    send(WB, 1, 1, 16'h0777);
    expect_msg("R8 owner data to reader", 1'b1, DAT, 0, 1, 16'h0777);
    send(RD, 2, 1, 0);
    expect_msg("R8 memory updated shared", 1'b1, DAT, 2, 1, 16'h0777);

    // R9: node 0 takes block 6 owned by node 3
    send(RDX, 0, 6, 0);
    expect_msg("R9 walk start", 1'b0, INV, 0, 0, 0);
    @(negedge clk);
    expect_msg("R9 inv owner", 1'b1, INV, 3, 6, 0);
    send(WB, 2, 6, 16'hbeef);
    expect_msg("R11 busy writeback nacked", 1'b1, NAK, 2, 6, 0);
    send(ACK, 3, 6, 16'h0abc);
    expect_msg("R9 owner data granted", 1'b1, EXC, 0, 6, 16'h0abc);
    send(WB, 0, 6, 16'h0def);
    expect_msg("R10 owner writeback silent", 1'b0, INV, 0, 0, 0);
    send(RD, 1, 6, 0);
    expect_msg("R10 writeback stored", 1'b1, DAT, 1, 6, 16'h0def);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule